// File: doc/BRIEF.md
# Byte-Addressed Two-Wire Register Target

This block is the target side of a two-wire (I2C) serial link. It connects that link to an on-chip register bank. A fast system clock oversamples SCL and SDA and detects START, repeated START and STOP. The block then compares the incoming 7-bit target address with its own. The upper five bits of that address are fixed. The lower two bits come from a strap pin that can be wired in one of four ways.

A write carries the address byte and then a register-pointer byte. Any number of data bytes may follow. Each data byte produces one write strobe at the current pointer, and the pointer then steps by one.

A read starts with a pointer write. The master then issues a repeated START and sends the address with the read bit set. The block shifts register contents out, MSB first. It advances the pointer after each byte the master acknowledges, and it stops driving the bus when the master does not acknowledge.

The register bank sees a plain parallel port. This port carries an 8-bit address (the pointer), 8-bit write data, a one-cycle write strobe, and 8-bit read data that the bank returns combinationally for the current address. SDA is open-drain: the block only asserts an output-enable that pulls the line low.

Top module: `i2c_regport`

## Requirements
- R1: An address byte whose upper seven bits equal 1101_1 followed by the two decoded strap bits is acknowledged (SDA pulled low in the ninth clock). Bit 0 of that byte selects write (0) or read (1), so the write addresses are 0xD8, 0xDA, 0xDC and 0xDE for strap codes 00, 01, 10 and 11.
- R2: An address byte that does not match is not acknowledged. The block then ignores all bus activity, producing no acknowledge and no write strobe, until the next START.
- R3: In a write, the first byte after the address byte is loaded as the register pointer and acknowledged, and it produces no write strobe.
- R4: Each later write byte, received MSB first, is acknowledged and produces exactly one single-cycle write strobe with that byte as write data and the current pointer as address.
- R5: The pointer increases by one after each acknowledged data byte, wrapping from 0xFF to 0x00.
- R6: After a pointer write, a repeated START and the address with the read bit set, the block shifts out the register at the pointer, MSB first.
- R7: In a read, each byte the master acknowledges advances the pointer, and the next byte comes from the new address. A byte the master does not acknowledge ends the read with SDA released.
- R8: A STOP (SDA rising while SCL is high) releases SDA and returns the block to idle, so bytes clocked afterwards without a START are not acknowledged.
- R9: While reset is held and right after it, SDA is not pulled and no write strobe is issued.
- R10: SDA changes while SCL is low are data, not bus conditions. A START (SDA falling while SCL is high) in the middle of a transfer restarts address reception and keeps the pointer.
- R11: The strap code is 00 when the strap stays low, 11 when it stays high, 01 when it follows SCL, and 10 when it follows SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 1 | Address strap pin (low, high, tied to SCL, or tied to SDA) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_addr | output | 8 | Register pointer presented to the bank |
| reg_wdata | output | 8 | Write data to the bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the bank for reg_addr |

## Verification
The bench runs the master side in open-drain form and ties the strap to ground, to supply, to SCL and to SDA in turn. For each strap setting it checks that only the matching address is acknowledged; a wrong strap decode would leave the block silent or make it answer the wrong address.

It writes at pointer 0xFF so that the pointer must wrap; a pointer that is too wide or that saturates would place the second byte at the wrong address. It also issues a repeated START in the middle of a write. A block that read that START as data would corrupt the pointer byte.

Reads cover several acknowledged bytes followed by a non-acknowledged one, and the bench checks that SDA is released afterwards. Bytes clocked after a STOP or after an address mismatch must produce no acknowledge and no strobe. A block that failed to return to idle would answer them or write the bank.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

    localparam int BYTE_W = 8;
    localparam logic [4:0] ADDR_HI = 5'b11011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } eng_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_ev_t;

    // Strap classification from what was observed since reset.
    function automatic logic [1:0] strap_code(input logic seen_lo,
                                              input logic seen_hi,
                                              input logic off_scl,
                                              input logic off_sda);
        logic [1:0] c;
        if (!seen_hi)      c = 2'b00;
        else if (!seen_lo) c = 2'b11;
        else if (!off_scl) c = 2'b01;
        else if (!off_sda) c = 2'b10;
        else               c = 2'b00;
        return c;
    endfunction

    function automatic logic addr_hit(input logic [6:0] a, input logic [1:0] strap);
        return a == {ADDR_HI, strap};
    endfunction

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] now,
    output logic [N-1:0] prev
);
    localparam int DEPTH = STAGES + 1;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [DEPTH-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[DEPTH-2:0], raw[i]};
        end
        assign now[i]  = chain[DEPTH-2];
        assign prev[i] = chain[DEPTH-1];
    end
endmodule

// File: rtl/i2c_rp_strap.sv
module i2c_rp_strap #(
    parameter int SETTLE = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       strap_s,
    output logic [1:0] code
);
    import i2c_rp_pkg::*;

    localparam int CW = $clog2(SETTLE + 1);

    logic [CW-1:0] settle_cnt;
    logic          live;
    logic          seen_lo, seen_hi, off_scl, off_sda;

    assign live = (settle_cnt == CW'(SETTLE));

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_cnt <= '0;
            seen_lo    <= 1'b0;
            seen_hi    <= 1'b0;
            off_scl    <= 1'b0;
            off_sda    <= 1'b0;
        end else if (!live) begin
            settle_cnt <= settle_cnt + 1'b1;
        end else begin
            if (!strap_s)        seen_lo <= 1'b1;
            if (strap_s)         seen_hi <= 1'b1;
            if (strap_s != scl_s) off_scl <= 1'b1;
            if (strap_s != sda_s) off_sda <= 1'b1;
        end
    end

    assign code = strap_code(seen_lo, seen_hi, off_scl, off_sda);
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine #(
    parameter int DW = i2c_rp_pkg::BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  i2c_rp_pkg::bus_ev_t  ev,
    input  logic                 sda_s,
    input  logic [1:0]           strap,
    input  logic [DW-1:0]        rd_data,
    output logic                 sda_oe,
    output logic [DW-1:0]        ptr,
    output logic [DW-1:0]        wdata,
    output logic                 we
);
    import i2c_rp_pkg::*;

    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW);

    eng_state_e    st;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic          rw;
    logic          mack;
    logic          rx_state;

    assign rx_state = (st == ST_ADDR) || (st == ST_PTR) || (st == ST_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            ptr    <= '0;
            wdata  <= '0;
            we     <= 1'b0;
            sda_oe <= 1'b0;
            rw     <= 1'b0;
            mack   <= 1'b0;
        end else begin
            we <= 1'b0;
            if (ev.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (rx_state) begin
                if (ev.scl_rise) begin
                    sh  <= {sh[DW-2:0], sda_s};
                    cnt <= cnt + 1'b1;
                end else if (ev.scl_fall && cnt == LAST) begin
                    cnt <= '0;
                    if (st == ST_ADDR) begin
                        if (addr_hit(sh[DW-1:1], strap)) begin
                            sda_oe <= 1'b1;
                            rw     <= sh[0];
                            st     <= ST_ADDR_ACK;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else if (st == ST_PTR) begin
                        ptr    <= sh;
                        sda_oe <= 1'b1;
                        st     <= ST_PTR_ACK;
                    end else begin
                        wdata  <= sh;
                        we     <= 1'b1;
                        sda_oe <= 1'b1;
                        st     <= ST_WR_ACK;
                    end
                end
            end else begin
                unique case (st)
                    ST_ADDR_ACK: if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[DW-1];
                            st     <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_PTR;
                        end
                    end
                    ST_PTR_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        st     <= ST_WR;
                    end
                    ST_WR_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                        st     <= ST_WR;
                    end
                    ST_RD: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == LAST) begin
                                cnt    <= '0;
                                sda_oe <= 1'b0;
                                st     <= ST_RD_ACK;
                            end else begin
                                sh     <= {sh[DW-2:0], 1'b0};
                                sda_oe <= ~sh[DW-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~sda_s;
                            if (!sda_s) ptr <= ptr + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[DW-1];
                                cnt    <= '0;
                                st     <= ST_RD;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       strap_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    import i2c_rp_pkg::*;

    localparam int NPIN = 3;
    localparam int P_SCL = 0;
    localparam int P_SDA = 1;
    localparam int P_STRAP = 2;

    logic [NPIN-1:0] pin_now, pin_prev;
    bus_ev_t         ev;
    logic            start_det, stop_det;
    logic [1:0]      strap_code_w;

    i2c_rp_sync #(.N(NPIN), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({strap_i, sda_i, scl_i}),
        .now  (pin_now),
        .prev (pin_prev)
    );

    always_comb begin
        ev.scl_rise = pin_now[P_SCL] & ~pin_prev[P_SCL];
        ev.scl_fall = ~pin_now[P_SCL] & pin_prev[P_SCL];
        ev.start    = pin_now[P_SCL] & pin_prev[P_SCL] & ~pin_now[P_SDA] & pin_prev[P_SDA];
        ev.stop     = pin_now[P_SCL] & pin_prev[P_SCL] & pin_now[P_SDA] & ~pin_prev[P_SDA];
    end

    assign start_det = ev.start;
    assign stop_det  = ev.stop;

    i2c_rp_strap #(.SETTLE(4)) u_strap (
        .clk     (clk),
        .rst     (rst),
        .scl_s   (pin_now[P_SCL]),
        .sda_s   (pin_now[P_SDA]),
        .strap_s (pin_now[P_STRAP]),
        .code    (strap_code_w)
    );

    i2c_rp_engine #(.DW(BYTE_W)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .sda_s   (pin_now[P_SDA]),
        .strap   (strap_code_w),
        .rd_data (reg_rdata),
        .sda_oe  (sda_oe),
        .ptr     (reg_addr),
        .wdata   (reg_wdata),
        .we      (reg_we)
    );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input logic       start_det,
    input logic       stop_det
);
    // R4: the write strobe lasts one cycle
    p_we_single_r4: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R4: strobes only fall inside the low phase of SCL
    p_we_scl_low_r4: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !scl_i);

    // R5: pointer does not move in the cycle after a strobe
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> reg_addr == $past(reg_addr));

    // R10: SDA drive changes only while SCL is low
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);

    // R8: a STOP releases SDA
    p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // R10: a START releases SDA
    p_start_release_r10: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);
endmodule

bind i2c_regport i2c_regport_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/i2c_regport_bench.sv
module i2c_regport_bench;

    localparam int Q = 8;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] d;
    } wr_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap_mode = 2'd0;
    logic       sda_line, strap_pin;
    logic       sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] bank [256];
    wr_t        exp_q [$];
    int         tests = 0;
    int         fails = 0;

    always #5 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign strap_pin = (strap_mode == 2'd0) ? 1'b0 :
                       (strap_mode == 2'd3) ? 1'b1 :
                       (strap_mode == 2'd1) ? m_scl : sda_line;
    assign reg_rdata = bank[reg_addr];

    i2c_regport u_i2c_regport (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .strap_i   (strap_pin),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compare strobes against expected queue, update bank
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected write strobe", {reg_addr, reg_wdata}, 0);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk(reg_addr == e.a && reg_wdata == e.d, "R4 write addr/data",
                    {reg_addr, reg_wdata}, {e.a, e.d});
            end
            bank[reg_addr] = reg_wdata;
        end
    end

    task automatic exp_wr(input logic [7:0] a, input logic [7:0] d);
        wr_t e;
        e.a = a;
        e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_scl = 1'b1;
        m_sda = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw();
            m_scl = 1'b1; qw(); qw();
            m_scl = 1'b0; qw();
        end
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        acked = ~sda_line;
        qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic rd_byte(output logic [7:0] b, input bit give_ack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            m_scl = 1'b1; qw();
            b[i] = sda_line;
            qw();
            m_scl = 1'b0;
        end
        qw();
        m_sda = ~give_ack; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
        m_sda = 1'b1;
    endtask

    task automatic q_empty(input string tag);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // strap check: wrong address refused, right one accepted and writable
    task automatic strap_case(input logic [1:0] mode, input logic [7:0] good,
                              input logic [7:0] bad, input logic [7:0] p,
                              input logic [7:0] d);
        bit ak;
        strap_mode = mode;
        do_reset();
        bus_start();
        wr_byte(bad, ak);
        chk(!ak, "R11 strap wrong address refused", ak, 0);
        bus_start();
        wr_byte(good, ak);
        chk(ak, "R11 strap matching address acked", ak, 1);
        wr_byte(p, ak);
        exp_wr(p, d);
        wr_byte(d, ak);
        chk(ak, "R1 data ack under strap", ak, 1);
        bus_stop();
        q_empty("R11 strap write landed");
    endtask

    initial begin
        bit         ak;
        logic [7:0] rb;
        for (int i = 0; i < 256; i++) bank[i] = 8'h00;

        // R9: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R9 sda released in reset", sda_oe, 0);
        chk(reg_we == 1'b0, "R9 no strobe in reset", reg_we, 0);
        do_reset();
        chk(sda_oe == 1'b0 && reg_we == 1'b0, "R9 idle after reset", {sda_oe, reg_we}, 0);

        // R1 R3 R4 R5: write with strap low, address 0xD8
        bus_start();
        wr_byte(8'hD8, ak);
        chk(ak, "R1 address D8 acked", ak, 1);
        wr_byte(8'h10, ak);
        chk(ak, "R3 pointer byte acked", ak, 1);
        exp_wr(8'h10, 8'hA5);
        wr_byte(8'hA5, ak);
        chk(ak, "R4 data byte acked", ak, 1);
        exp_wr(8'h11, 8'h3C);
        wr_byte(8'h3C, ak);
        exp_wr(8'h12, 8'h5A);
        wr_byte(8'h5A, ak);
        chk(ak, "R5 third byte acked", ak, 1);
        bus_stop();
        q_empty("R5 auto-increment writes all seen");

        // R2: wrong address (strap 01 pattern) with strap low
        bus_start();
        wr_byte(8'hDA, ak);
        chk(!ak, "R2 mismatched address not acked", ak, 0);
        wr_byte(8'h20, ak);
        chk(!ak, "R2 later byte not acked", ak, 0);
        wr_byte(8'h77, ak);
        chk(!ak, "R2 data byte ignored", ak, 0);
        bus_stop();
        q_empty("R2 no strobe after mismatch");

        // R6 R7: read back three bytes from 0x10
        bus_start();
        wr_byte(8'hD8, ak);
        wr_byte(8'h10, ak);
        chk(ak, "R6 read pointer acked", ak, 1);
        bus_start();
        wr_byte(8'hD9, ak);
        chk(ak, "R6 read address acked", ak, 1);
        rd_byte(rb, 1'b1);
        chk(rb == 8'hA5, "R6 first read byte", rb, 8'hA5);
        rd_byte(rb, 1'b1);
        chk(rb == 8'h3C, "R7 second read byte", rb, 8'h3C);
        rd_byte(rb, 1'b0);
        chk(rb == 8'h5A, "R7 third read byte", rb, 8'h5A);
        qw();
        chk(sda_oe == 1'b0, "R7 sda released after master nack", sda_oe, 0);
        qw(); qw();
        chk(sda_oe == 1'b0, "R7 sda still released", sda_oe, 0);
        bus_stop();

        // R5: pointer wrap from FF to 00
        bus_start();
        wr_byte(8'hD8, ak);
        wr_byte(8'hFF, ak);
        exp_wr(8'hFF, 8'h11);
        wr_byte(8'h11, ak);
        exp_wr(8'h00, 8'h22);
        wr_byte(8'h22, ak);
        chk(ak, "R5 byte after wrap acked", ak, 1);
        bus_stop();
        q_empty("R5 wrap writes seen");

        // R10: repeated START during write restarts address, data bits alternating
        bus_start();
        wr_byte(8'hD8, ak);
        wr_byte(8'h20, ak);
        exp_wr(8'h20, 8'h55);
        wr_byte(8'h55, ak);
        bus_start();
        wr_byte(8'hD8, ak);
        chk(ak, "R10 address after repeated start acked", ak, 1);
        wr_byte(8'h30, ak);
        exp_wr(8'h30, 8'hAA);
        wr_byte(8'hAA, ak);
        bus_stop();
        q_empty("R10 writes around repeated start");

        // R8: bytes after STOP without START are ignored
        bus_start();
        wr_byte(8'hD8, ak);
        bus_stop();
        chk(sda_oe == 1'b0, "R8 released at stop", sda_oe, 0);
        m_scl = 1'b0; qw();
        wr_byte(8'hD8, ak);
        chk(!ak, "R8 no ack without start", ak, 0);
        wr_byte(8'h40, ak);
        chk(!ak, "R8 second byte ignored", ak, 0);
        m_scl = 1'b1; qw();
        q_empty("R8 no strobe after stop");

        // R11: other strap connections
        strap_case(2'd3, 8'hDE, 8'hD8, 8'h50, 8'hC3);
        strap_case(2'd1, 8'hDA, 8'hD8, 8'h51, 8'h96);
        strap_case(2'd2, 8'hDC, 8'hDA, 8'h52, 8'h69);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule